// File: doc/BRIEF.md
# Interrupt Controller Register Bank

This block is the software-visible state of a 64-source vectored interrupt controller. It keeps three 64-bit vectors: which sources are enabled, which are routed as fast rather than normal interrupts, and which are currently pending. It also keeps a 5-bit normal-interrupt threshold, a control word and eight 32-bit priority words that hold one 4-bit priority per source. Software reaches all of this through a simple word-aligned register bus. Every 64-bit vector is split into a high word and a low word at separate addresses.

Pending bits follow level-sensitive source inputs. Software can also force a pending half outright. The block drives the fast-interrupt request itself. For the normal path it only exports the masked pending vector, the priority words and the threshold. A separate resolver uses these and hands back its winning source. The bank reports that winner when software reads the normal or fast vector register, and clears the winner's pending bit in the same cycle.

Top module: `irq_regbank`

## Requirements
- R1: After reset the threshold reads 0x1F (index 1). Enables, types, control, priority words, pending state and the fast request are all zero.
- R2: A write to index 2 sets the enable bit numbered by write-data bits [5:0]. A write to index 3 clears that bit. Both indices read as zero.
- R3: Indices 4/5 hold the enable vector high/low words and indices 6/7 hold the type vector high/low words (type 1 = fast). Each reads back what was written. Control (index 0) keeps only the bits of the control write mask, which defaults to the low 8 bits.
- R4: The threshold register (index 1) keeps only write-data bits [4:0].
- R5: Priority index k (8..15, byte address 4k) holds priority word 15−k. Word w carries the 4-bit priorities of sources 8w..8w+7, with source 8w in bits [3:0]. It is exported at prio_words[32w +: 32].
- R6: Each cycle a pending bit takes its source level. A write to index 20 (high) or 21 (low) instead loads that pending half from the write data for that cycle. Both force indices read as zero.
- R7: Index 18/19 return raw pending high/low. Index 22/23 return pending AND enable AND NOT type. Index 24/25 return pending AND enable AND type. The same normal and fast vectors appear on norm_pend and fast_pend.
- R8: fast_irq is high in exactly the cycles in which some bit is pending, enabled and of fast type.
- R9: A read of index 16 returns {source number in bits [21:16], priority in bits [3:0]} of the resolver's normal winner, or all ones if there is none. A read of index 17 returns the fast winner's number, or all ones if there is none. A read that returns a winner clears that winner's pending bit in that cycle, and this takes precedence over its source level.
- R10: Writes to indices 16–19 and 22–25 change nothing. Writes to byte addresses 0x100–0x2FC are discarded without error. A read of index 0x40 returns 4.
- R11: An access to an undefined index, or to an address that is not word-aligned, reads as zero, changes nothing, and raises rsp_err for exactly one cycle after the request.
- R12: Every accepted read gives rsp_valid with its data one cycle after the request. Writes give no rsp_valid. req_ready is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 64 | Level-sensitive source inputs |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted (constant 1) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | One-cycle error pulse for an undefined access |
| nsel_valid | input | 1 | Resolver has a normal winner |
| nsel_idx | input | 6 | Normal winner source number |
| nsel_prio | input | 4 | Normal winner priority |
| fsel_valid | input | 1 | Resolver has a fast winner |
| fsel_idx | input | 6 | Fast winner source number |
| fast_irq | output | 1 | Fast-interrupt request |
| norm_pend | output | 64 | Pending, enabled, normal-type sources |
| fast_pend | output | 64 | Pending, enabled, fast-type sources |
| norm_mask | output | 5 | Normal-interrupt threshold |
| prio_words | output | 256 | All eight priority words |
| ctrl_word | output | 32 | Control register contents |

## Verification
A decode fault, such as a swapped half or a priority word in mirror order, shows up in the readback of the very next access and on prio_words in the cycle after the write. An enable or type bit stored wrongly appears at once on norm_pend, fast_pend and fast_irq, because these are driven from state with no further delay. A pending bit that fails to follow its source, or to take a force or a winner clear, is visible on those same ports one cycle after the event. A missing or doubled rsp_err pulse appears in the cycle after the stray access.

// File: rtl/irq_regbank_pkg.sv
package irq_regbank_pkg;

  typedef enum logic [4:0] {
    RK_CTRL, RK_MASK, RK_ENNUM, RK_DISNUM,
    RK_ENHI, RK_ENLO, RK_TYHI, RK_TYLO,
    RK_PRIO, RK_NVEC, RK_FVEC,
    RK_SRCHI, RK_SRCLO, RK_FRCHI, RK_FRCLO,
    RK_NPHI, RK_NPLO, RK_FPHI, RK_FPLO,
    RK_MAGIC, RK_VSLOT, RK_BAD
  } reg_kind_e;

  localparam int unsigned MAGIC_IDX = 64;
  localparam int unsigned VSLOT_LAST_IDX = 191;
  localparam int unsigned MAGIC_VALUE = 4;

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_regbank_pkg::*;
#(
  parameter int unsigned AW  = 12,
  parameter int unsigned PSW = 3
) (
  input  logic [AW-1:0]  addr,
  output reg_kind_e      kind,
  output logic [PSW-1:0] prio_sel
);
  localparam int unsigned IW = AW - 2;

  logic [IW-1:0] idx;
  assign idx = addr[AW-1:2];
  // index 8 -> word 7 ... index 15 -> word 0
  assign prio_sel = ~idx[PSW-1:0];

  always_comb begin
    kind = RK_BAD;
    if (addr[1:0] != 2'b00) begin
      kind = RK_BAD;
    end else if (idx < IW'(26)) begin
      case (idx[4:0])
        5'd0:  kind = RK_CTRL;
        5'd1:  kind = RK_MASK;
        5'd2:  kind = RK_ENNUM;
        5'd3:  kind = RK_DISNUM;
        5'd4:  kind = RK_ENHI;
        5'd5:  kind = RK_ENLO;
        5'd6:  kind = RK_TYHI;
        5'd7:  kind = RK_TYLO;
        5'd16: kind = RK_NVEC;
        5'd17: kind = RK_FVEC;
        5'd18: kind = RK_SRCHI;
        5'd19: kind = RK_SRCLO;
        5'd20: kind = RK_FRCHI;
        5'd21: kind = RK_FRCLO;
        5'd22: kind = RK_NPHI;
        5'd23: kind = RK_NPLO;
        5'd24: kind = RK_FPHI;
        5'd25: kind = RK_FPLO;
        default: kind = RK_PRIO;
      endcase
    end else if (idx == IW'(MAGIC_IDX)) begin
      kind = RK_MAGIC;
    end else if (idx > IW'(MAGIC_IDX) && idx <= IW'(VSLOT_LAST_IDX)) begin
      kind = RK_VSLOT;
    end
  end
endmodule

// File: rtl/irq_src_state.sv
module irq_src_state #(
  parameter int unsigned NSRC = 64,
  parameter int unsigned DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_lvl,
  input  logic [DW-1:0]   wdata,
  input  logic [1:0]      en_wr,
  input  logic [1:0]      ty_wr,
  input  logic [1:0]      frc_wr,
  input  logic [NSRC-1:0] en_set,
  input  logic [NSRC-1:0] en_clr,
  input  logic [NSRC-1:0] vec_clr,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] ty_q,
  output logic [NSRC-1:0] pend_q,
  output logic            fast_irq_q
);
  localparam int unsigned NHALF = NSRC / DW;

  logic [NSRC-1:0] en_n, ty_n, pend_n;

  always_comb begin
    en_n   = en_q;
    ty_n   = ty_q;
    pend_n = src_lvl;
    for (int h = 0; h < NHALF; h++) begin
      if (en_wr[h])  en_n[h*DW +: DW]   = wdata;
      if (ty_wr[h])  ty_n[h*DW +: DW]   = wdata;
      if (frc_wr[h]) pend_n[h*DW +: DW] = wdata;
    end
    en_n   = (en_n | en_set) & ~en_clr;
    pend_n = pend_n & ~vec_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= '0;
      ty_q       <= '0;
      pend_q     <= '0;
      fast_irq_q <= 1'b0;
    end else begin
      en_q       <= en_n;
      ty_q       <= ty_n;
      pend_q     <= pend_n;
      fast_irq_q <= |(pend_n & en_n & ty_n);
    end
  end
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank #(
  parameter int unsigned NW  = 8,
  parameter int unsigned DW  = 32,
  parameter int unsigned PSW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PSW-1:0]   wsel,
  input  logic [DW-1:0]    wdata,
  input  logic [PSW-1:0]   rsel,
  output logic [DW-1:0]    rdata,
  output logic [NW*DW-1:0] flat
);
  logic [DW-1:0] words [NW];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) words[i] <= '0;
    end else if (we) begin
      words[wsel] <= wdata;
    end
  end

  assign rdata = words[rsel];

  for (genvar w = 0; w < NW; w++) begin : g_flat
    assign flat[w*DW +: DW] = words[w];
  end
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
  import irq_regbank_pkg::*;
#(
  parameter int unsigned NSRC       = 64,
  parameter int unsigned DW         = 32,
  parameter int unsigned AW         = 12,
  parameter int unsigned MASKW      = 5,
  parameter int unsigned PRIOW      = 4,
  parameter int unsigned PRIO_WORDS = 8,
  parameter logic [31:0] CTRL_WMASK = 32'h0000_00FF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NSRC-1:0]          src_lvl,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [AW-1:0]            req_addr,
  input  logic [DW-1:0]            req_wdata,
  output logic                     req_ready,
  output logic                     rsp_valid,
  output logic [DW-1:0]            rsp_rdata,
  output logic                     rsp_err,
  input  logic                     nsel_valid,
  input  logic [$clog2(NSRC)-1:0]  nsel_idx,
  input  logic [PRIOW-1:0]         nsel_prio,
  input  logic                     fsel_valid,
  input  logic [$clog2(NSRC)-1:0]  fsel_idx,
  output logic                     fast_irq,
  output logic [NSRC-1:0]          norm_pend,
  output logic [NSRC-1:0]          fast_pend,
  output logic [MASKW-1:0]         norm_mask,
  output logic [PRIO_WORDS*DW-1:0] prio_words,
  output logic [DW-1:0]            ctrl_word
);
  localparam int unsigned IDXW = $clog2(NSRC);
  localparam int unsigned PSW  = $clog2(PRIO_WORDS);
  localparam int unsigned VEC_IDX_LSB = 16;

  reg_kind_e       kind;
  logic [PSW-1:0]  prio_sel;
  logic            wr, rd;
  logic [NSRC-1:0] en_q, ty_q, pend_q;
  logic [NSRC-1:0] en_set, en_clr, vec_clr;
  logic [1:0]      en_wr, ty_wr, frc_wr;
  logic [DW-1:0]   prio_rd, rdata_n;
  logic [MASKW-1:0] mask_q;
  logic [DW-1:0]   ctrl_q;
  logic            fast_irq_q;

  assign wr = req_valid & req_write;
  assign rd = req_valid & ~req_write;
  assign req_ready = 1'b1;

  irq_addr_dec #(.AW(AW), .PSW(PSW)) u_dec (
    .addr(req_addr), .kind(kind), .prio_sel(prio_sel)
  );

  assign en_wr  = {wr && kind == RK_ENHI,  wr && kind == RK_ENLO};
  assign ty_wr  = {wr && kind == RK_TYHI,  wr && kind == RK_TYLO};
  assign frc_wr = {wr && kind == RK_FRCHI, wr && kind == RK_FRCLO};
  assign en_set = (wr && kind == RK_ENNUM)  ? (NSRC'(1) << req_wdata[IDXW-1:0]) : '0;
  assign en_clr = (wr && kind == RK_DISNUM) ? (NSRC'(1) << req_wdata[IDXW-1:0]) : '0;

  always_comb begin
    vec_clr = '0;
    if (rd && kind == RK_NVEC && nsel_valid) vec_clr = NSRC'(1) << nsel_idx;
    if (rd && kind == RK_FVEC && fsel_valid) vec_clr = NSRC'(1) << fsel_idx;
  end

  irq_src_state #(.NSRC(NSRC), .DW(DW)) u_state (
    .clk(clk), .rst(rst), .src_lvl(src_lvl), .wdata(req_wdata),
    .en_wr(en_wr), .ty_wr(ty_wr), .frc_wr(frc_wr),
    .en_set(en_set), .en_clr(en_clr), .vec_clr(vec_clr),
    .en_q(en_q), .ty_q(ty_q), .pend_q(pend_q), .fast_irq_q(fast_irq_q)
  );

  irq_prio_bank #(.NW(PRIO_WORDS), .DW(DW), .PSW(PSW)) u_prio (
    .clk(clk), .rst(rst), .we(wr && kind == RK_PRIO), .wsel(prio_sel),
    .wdata(req_wdata), .rsel(prio_sel), .rdata(prio_rd), .flat(prio_words)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      ctrl_q <= '0;
    end else if (wr) begin
      if (kind == RK_MASK) mask_q <= req_wdata[MASKW-1:0];
      if (kind == RK_CTRL) ctrl_q <= req_wdata & CTRL_WMASK[DW-1:0];
    end
  end

  assign norm_pend = pend_q & en_q & ~ty_q;
  assign fast_pend = pend_q & en_q & ty_q;
  assign norm_mask = mask_q;
  assign ctrl_word = ctrl_q;
  assign fast_irq  = fast_irq_q;

  always_comb begin
    rdata_n = '0;
    case (kind)
      RK_CTRL:  rdata_n = ctrl_q;
      RK_MASK:  rdata_n = DW'(mask_q);
      RK_ENHI:  rdata_n = en_q[NSRC-1:DW];
      RK_ENLO:  rdata_n = en_q[DW-1:0];
      RK_TYHI:  rdata_n = ty_q[NSRC-1:DW];
      RK_TYLO:  rdata_n = ty_q[DW-1:0];
      RK_PRIO:  rdata_n = prio_rd;
      RK_NVEC:  rdata_n = nsel_valid ?
                  ((DW'(nsel_idx) << VEC_IDX_LSB) | DW'(nsel_prio)) : '1;
      RK_FVEC:  rdata_n = fsel_valid ? DW'(fsel_idx) : '1;
      RK_SRCHI: rdata_n = pend_q[NSRC-1:DW];
      RK_SRCLO: rdata_n = pend_q[DW-1:0];
      RK_NPHI:  rdata_n = norm_pend[NSRC-1:DW];
      RK_NPLO:  rdata_n = norm_pend[DW-1:0];
      RK_FPHI:  rdata_n = fast_pend[NSRC-1:DW];
      RK_FPLO:  rdata_n = fast_pend[DW-1:0];
      RK_MAGIC: rdata_n = DW'(MAGIC_VALUE);
      default:  rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rdata_n : '0;
      rsp_err   <= req_valid && kind == RK_BAD;
    end
  end
endmodule

// File: rtl/irq_regbank_chk.sv
module irq_regbank_chk #(
  parameter int unsigned NSRC  = 64,
  parameter int unsigned AW    = 12,
  parameter int unsigned DW    = 32,
  parameter int unsigned MASKW = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_write,
  input logic [AW-1:0]   req_addr,
  input logic [DW-1:0]   req_wdata,
  input logic            rsp_valid,
  input logic            rsp_err,
  input logic            fast_irq,
  input logic [NSRC-1:0] norm_pend,
  input logic [NSRC-1:0] fast_pend,
  input logic [MASKW-1:0] norm_mask,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] ty_q
);
  localparam int unsigned IDXW = $clog2(NSRC);

  logic [AW-3:0] widx;
  assign widx = req_addr[AW-1:2];

  // R1
  rst_state_chk: assert property (@(posedge clk)
    rst |=> (norm_mask == '1 && en_q == '0 && ty_q == '0 && !fast_irq));

  // R2
  ennum_set_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr[1:0] == 2'b00 && widx == (AW-2)'(2))
      |=> en_q[$past(req_wdata[IDXW-1:0])]);

  // R2
  disnum_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr[1:0] == 2'b00 && widx == (AW-2)'(3))
      |=> !en_q[$past(req_wdata[IDXW-1:0])]);

  // R7
  view_split_chk: assert property (@(posedge clk) disable iff (rst)
    (norm_pend & fast_pend) == '0);

  // R8
  fast_req_chk: assert property (@(posedge clk) disable iff (rst)
    fast_irq == (|fast_pend));

  // R10
  ro_write_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr[1:0] == 2'b00 && widx >= (AW-2)'(16) && widx <= (AW-2)'(19))
      |=> ($stable(en_q) && $stable(ty_q)));

  // R11
  err_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> $past(req_valid));

  // R12
  rsp_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write));
endmodule

bind irq_regbank irq_regbank_chk #(.NSRC(NSRC), .AW(AW), .DW(DW), .MASKW(MASKW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .fast_irq(fast_irq), .norm_pend(norm_pend),
  .fast_pend(fast_pend), .norm_mask(norm_mask), .en_q(en_q), .ty_q(ty_q)
);

// File: tb/irq_regbank_test.sv
module irq_regbank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_lvl = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err, fast_irq;
  logic [31:0] rsp_rdata, ctrl_word;
  logic        nsel_valid = 1'b0, fsel_valid = 1'b0;
  logic [5:0]  nsel_idx = '0, fsel_idx = '0;
  logic [3:0]  nsel_prio = '0;
  logic [63:0] norm_pend, fast_pend;
  logic [4:0]  norm_mask;
  logic [255:0] prio_words;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_regbank uut (
    .clk(clk), .rst(rst), .src_lvl(src_lvl), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .nsel_valid(nsel_valid), .nsel_idx(nsel_idx),
    .nsel_prio(nsel_prio), .fsel_valid(fsel_valid), .fsel_idx(fsel_idx),
    .fast_irq(fast_irq), .norm_pend(norm_pend), .fast_pend(fast_pend),
    .norm_mask(norm_mask), .prio_words(prio_words), .ctrl_word(ctrl_word)
  );

  function automatic logic [63:0] exp_norm(logic [63:0] p, logic [63:0] e, logic [63:0] t);
    return p & e & ~t;
  endfunction
  function automatic logic [63:0] exp_fast(logic [63:0] p, logic [63:0] e, logic [63:0] t);
    return p & e & t;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] rdat, output logic err, output logic rv);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    rdat = rsp_rdata; err = rsp_err; rv = rsp_valid;
    req_valid = 1'b0;
  endtask

  logic [31:0] rdat;
  logic err, rv;

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    acc(1'b1, a, d, rdat, err, rv);
  endtask
  task automatic rdr(input logic [11:0] a);
    acc(1'b0, a, 32'h0, rdat, err, rv);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] m_en, m_ty, m_src;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rdr(12'h004); chk("R1 mask reset", rdat, 32'h1F);
    rdr(12'h010); chk("R1 enable hi reset", rdat, 0);
    chk("R1 fast_irq reset", fast_irq, 0);
    chk("R1 prio reset", prio_words[63:0], 0);
    chk("R12 read gives rsp_valid", rv, 1);

    // R4 threshold width
    wr(12'h004, 32'hFFFF_FFE3);
    chk("R12 write gives no rsp_valid", rv, 0);
    rdr(12'h004); chk("R4 mask keeps 5 bits", rdat, 32'h03);

    // R3 control mask
    wr(12'h000, 32'hFFFF_FFFF);
    rdr(12'h000); chk("R3 control masked", rdat, 32'hFF);

    // R2 enable/disable by number
    wr(12'h008, 32'h47);
    rdr(12'h014); chk("R2 enable by number", rdat, 32'h80);
    rdr(12'h008); chk("R2 enable-number reads zero", rdat, 0);
    wr(12'h008, 32'd63);
    rdr(12'h010); chk("R2 enable 63 in high word", rdat, 32'h8000_0000);
    wr(12'h00C, 32'h07);
    rdr(12'h014); chk("R2 disable by number", rdat, 0);
    rdr(12'h00C); chk("R2 disable-number reads zero", rdat, 0);

    // R3 halves
    wr(12'h010, 32'hDEAD_BEEF); wr(12'h014, 32'h1234_5678);
    wr(12'h018, 32'hCAFE_0001); wr(12'h01C, 32'h0F0F_0F0F);
    rdr(12'h010); chk("R3 enable hi", rdat, 32'hDEAD_BEEF);
    rdr(12'h014); chk("R3 enable lo", rdat, 32'h1234_5678);
    rdr(12'h018); chk("R3 type hi", rdat, 32'hCAFE_0001);
    rdr(12'h01C); chk("R3 type lo", rdat, 32'h0F0F_0F0F);

    // R5 priority word order
    wr(12'h020, 32'hA000_0000);
    chk("R5 index 8 -> word 7", prio_words[7*32 +: 32], 32'hA000_0000);
    wr(12'h03C, 32'h0000_0005);
    chk("R5 index 15 -> word 0", prio_words[31:0], 32'h5);
    wr(12'h028, 32'h0000_0C00);
    chk("R5 index 10 -> word 5", prio_words[5*32 +: 32], 32'h0C00);
    rdr(12'h020); chk("R5 readback index 8", rdat, 32'hA000_0000);

    // R6 force
    src_lvl = '0;
    wr(12'h054, 32'h0000_1234);
    rdr(12'h04C); chk("R6 force lo loads pending", rdat, 32'h1234);
    rdr(12'h04C); chk("R6 pending returns to source", rdat, 0);
    wr(12'h050, 32'h8000_0000);
    rdr(12'h048); chk("R6 force hi loads pending", rdat, 32'h8000_0000);
    rdr(12'h054); chk("R6 force reads zero", rdat, 0);

    // R7/R8 random views
    for (int it = 0; it < 40; it++) begin
      m_src = {$urandom, $urandom};
      m_en  = {$urandom, $urandom};
      m_ty  = (it % 5 == 0) ? 64'h0 : {$urandom, $urandom};
      src_lvl = m_src;
      wr(12'h010, m_en[63:32]); wr(12'h014, m_en[31:0]);
      wr(12'h018, m_ty[63:32]); wr(12'h01C, m_ty[31:0]);
      rdr(12'h058); chk("R7 normal hi", rdat, exp_norm(m_src, m_en, m_ty) >> 32);
      rdr(12'h05C); chk("R7 normal lo", rdat, exp_norm(m_src, m_en, m_ty) & 64'hFFFF_FFFF);
      rdr(12'h060); chk("R7 fast hi", rdat, exp_fast(m_src, m_en, m_ty) >> 32);
      rdr(12'h064); chk("R7 fast lo", rdat, exp_fast(m_src, m_en, m_ty) & 64'hFFFF_FFFF);
      rdr(12'h048); chk("R7 source hi", rdat, m_src >> 32);
      chk("R7 norm_pend port", norm_pend, exp_norm(m_src, m_en, m_ty));
      chk("R8 fast_irq", fast_irq, |exp_fast(m_src, m_en, m_ty));
    end

    // R9 normal vector
    src_lvl = 64'h20;
    wr(12'h010, '1); wr(12'h014, '1); wr(12'h018, 0); wr(12'h01C, 0);
    nsel_valid = 1'b1; nsel_idx = 6'd5; nsel_prio = 4'd9;
    rdr(12'h040); chk("R9 normal vector word", rdat, 32'h0005_0009);
    chk("R9 winner cleared over level", norm_pend[5], 0);
    nsel_valid = 1'b0;
    rdr(12'h040); chk("R9 normal vector empty", rdat, 32'hFFFF_FFFF);
    chk("R9 level returns after clear", norm_pend[5], 1);

    // R9 fast vector, R8 drop
    src_lvl = 64'h1 << 40;
    wr(12'h018, 32'h100);
    chk("R8 fast_irq raised", fast_irq, 1);
    fsel_valid = 1'b1; fsel_idx = 6'd40;
    rdr(12'h044); chk("R9 fast vector word", rdat, 32'd40);
    chk("R8 fast_irq drops on clear", fast_irq, 0);
    fsel_valid = 1'b0;
    rdr(12'h044); chk("R9 fast vector empty", rdat, 32'hFFFF_FFFF);

    // R10 ignored writes and magic word
    wr(12'h048, 32'h0); chk("R10 ro write no error", err, 0);
    wr(12'h058, 32'h0);
    wr(12'h040, 32'h0);
    rdr(12'h010); chk("R10 enable hi unchanged", rdat, 32'hFFFF_FFFF);
    rdr(12'h018); chk("R10 type hi unchanged", rdat, 32'h100);
    wr(12'h100, 32'h1); chk("R10 vector slot write no error", err, 0);
    wr(12'h2FC, 32'h1); chk("R10 last slot no error", err, 0);
    rdr(12'h100); chk("R10 magic read", rdat, 32'd4);

    // R11 undefined accesses
    rdr(12'h068); chk("R11 undefined read zero", rdat, 0);
    chk("R11 undefined read err", err, 1);
    @(posedge clk); #1; chk("R11 err one cycle", rsp_err, 0);
    wr(12'h080, 32'h0); chk("R11 undefined write err", err, 1);
    wr(12'h012, 32'h0); chk("R11 misaligned err", err, 1);
    rdr(12'h010); chk("R11 misaligned write ignored", rdat, 32'hFFFF_FFFF);
    chk("R11 no err on good access", err, 0);
    wr(12'h300, 32'h0); chk("R11 past slots err", err, 1);
    chk("R12 ready high", req_ready, 1);

    finish_run();
  end
endmodule